// File: doc/BRIEF.md
# Decoupled access/execute queue interface

This block couples an address-generating access pipe to a compute pipe through three architectural FIFOs. Memory returns load data into a load queue that the compute pipe drains. The compute pipe fills a store data queue, and each entry is matched against a store address that the access pipe issued. The access pipe also resolves branches and queues each outcome so that the compute pipe can branch without evaluating a condition. The two pipes keep separate register files. Every value that passes between them goes through these queues.

On the compute side, one register number (parameter `QUEUE_REG`, 7 by default) is reserved. A read of that register pops the load queue head, and a write to it pushes the store data queue. A branch-from-queue operation pops one outcome. If a queue cannot serve a request, the block holds the requesting pipe. A stalled cycle changes no queue, and the pipe retries the same operation later. A store goes out to memory only when both its address and its data are present. It is held until memory accepts it.

Top module: `decoupled_queue_if`

## Requirements
- R1: After synchronous active-high reset, all queues are empty: `ldq_empty`, `sdq_empty` and `brq_empty` are 1, all `*_full` flags are 0, and `st_out_valid` is 0.
- R2: A compute read with `ex_rd_idx == QUEUE_REG` presents the load queue head on `ex_rd_data` and pops it, in arrival order, each entry once. A read of any other index leaves the load queue unchanged.
- R3: A compute write with `ex_wr_idx == QUEUE_REG` pushes `ex_wr_data` into the store data queue. A write to any other index pushes nothing.
- R4: `st_out_valid` is 1 only when the store address queue and the store data queue are both non-empty. It then presents the oldest address with the oldest data. The pair is held stable until a cycle with `st_out_ready` = 1 releases it.
- R5: An access push (`ac_br_valid`) enqueues `ac_br_taken`. A compute `ex_bfq` pops one outcome, which is presented on `ex_bfq_taken` in push order.
- R6: A mapped read while the load queue is empty raises `ex_stall`, pops nothing, and suppresses every other compute queue operation in that cycle. Data that arrives in that cycle is read on the retry.
- R7: `ex_stall` is raised by a mapped write while the store data queue is full, or by `ex_bfq` while the branch queue is empty. `ac_stall` is raised by `ac_br_valid` while the branch queue is full, or by `ac_st_valid` while the store address queue is full. A stalled operation enqueues or dequeues nothing.
- R8: Each queue holds `DEPTH` entries (8 by default). Its full flag rises after `DEPTH` net pushes, and its empty flag rises when it holds none. These flags are registered. `mem_ld_ready` equals the inverse of `ldq_full`, and a load offered while the queue is full is dropped.
- R9: A push and a pop on the same non-empty, non-full queue in one cycle are both performed, and the occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_ld_valid | input | 1 | Memory offers a load data word |
| mem_ld_data | input | DATA_W | Load data word |
| mem_ld_ready | output | 1 | Load queue can accept |
| ac_st_valid | input | 1 | Access pipe issues a store address |
| ac_st_addr | input | ADDR_W | Store address |
| ac_br_valid | input | 1 | Access pipe pushes a branch outcome |
| ac_br_taken | input | 1 | Branch outcome (1 = taken) |
| ac_stall | output | 1 | Hold the access pipe |
| ex_rd_en | input | 1 | Compute register read |
| ex_rd_idx | input | REG_IDX_W | Compute read register number |
| ex_rd_data | output | DATA_W | Load queue head |
| ex_wr_en | input | 1 | Compute register write |
| ex_wr_idx | input | REG_IDX_W | Compute write register number |
| ex_wr_data | input | DATA_W | Compute write data |
| ex_bfq | input | 1 | Branch-from-queue operation |
| ex_bfq_taken | output | 1 | Branch queue head outcome |
| ex_stall | output | 1 | Hold the compute pipe |
| st_out_valid | output | 1 | Paired store ready for memory |
| st_out_addr | output | ADDR_W | Paired store address |
| st_out_data | output | DATA_W | Paired store data |
| st_out_ready | input | 1 | Memory accepts the store |
| ldq_full | output | 1 | Load queue full |
| ldq_empty | output | 1 | Load queue empty |
| sdq_full | output | 1 | Store data queue full |
| sdq_empty | output | 1 | Store data queue empty |
| brq_full | output | 1 | Branch queue full |
| brq_empty | output | 1 | Branch queue empty |

## Verification
The bench builds the block with `DEPTH` = 8, `DATA_W` = 16, `ADDR_W` = 8, `REG_IDX_W` = 5 and the mapped register at 7. At this depth every occupancy of every queue, from empty to full, is reached within a few cycles. Both stall edges can therefore be exercised on each queue, including writes offered while full and pops requested while empty. The store address and data queues are each filled alone first. This makes the pairing rule visible at both ends. Expected data, addresses and branch outcomes come from arithmetic on the entry number.

// File: rtl/daeq_pkg.sv
package daeq_pkg;

  // Advance a ring pointer with wrap at the queue depth.
  function automatic int unsigned ring_next(int unsigned ptr, int unsigned depth);
    return (ptr + 1 == depth) ? 0 : ptr + 1;
  endfunction

  // Occupancy after one cycle of accepted push and pop.
  function automatic int unsigned occ_after(int unsigned occ, logic push, logic pop);
    int unsigned r;
    r = occ;
    if (push && !pop) r = occ + 1;
    if (pop && !push) r = occ - 1;
    return r;
  endfunction

endpackage

// File: rtl/daeq_fifo.sv
module daeq_fifo
  import daeq_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   occ
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] occ_q, occ_n;
  logic          full_q, empty_q;
  logic          push_ok, pop_ok;

  assign push_ok = push && !full_q;
  assign pop_ok  = pop && !empty_q;
  assign occ_n   = CW'(occ_after(32'(occ_q), push_ok, pop_ok));

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      occ_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      if (push_ok) wp <= PW'(ring_next(32'(wp), DEPTH));
      if (pop_ok)  rp <= PW'(ring_next(32'(rp), DEPTH));
      occ_q   <= occ_n;
      full_q  <= (occ_n == CW'(DEPTH));
      empty_q <= (occ_n == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) store[wp] <= push_data;
  end

  assign head  = store[rp];
  assign full  = full_q;
  assign empty = empty_q;
  assign occ   = occ_q;
endmodule

// File: rtl/daeq_store_pair.sv
module daeq_store_pair #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        addr_push,
  input  logic [ADDR_W-1:0]           addr_in,
  input  logic                        data_push,
  input  logic [DATA_W-1:0]           data_in,
  input  logic                        out_ready,
  output logic                        out_valid,
  output logic [ADDR_W-1:0]           out_addr,
  output logic [DATA_W-1:0]           out_data,
  output logic                        addr_full,
  output logic                        data_full,
  output logic                        data_empty,
  output logic [$clog2(DEPTH+1)-1:0]  addr_occ,
  output logic [$clog2(DEPTH+1)-1:0]  data_occ
);
  logic addr_empty;
  logic release_pair;

  // A store leaves only as a complete address/data pair.
  assign out_valid    = !addr_empty && !data_empty;
  assign release_pair = out_valid && out_ready;

  daeq_fifo #(.W(ADDR_W), .DEPTH(DEPTH)) u_addr_q (
    .clk(clk), .rst(rst),
    .push(addr_push), .push_data(addr_in),
    .pop(release_pair), .head(out_addr),
    .full(addr_full), .empty(addr_empty), .occ(addr_occ)
  );

  daeq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_data_q (
    .clk(clk), .rst(rst),
    .push(data_push), .push_data(data_in),
    .pop(release_pair), .head(out_data),
    .full(data_full), .empty(data_empty), .occ(data_occ)
  );
endmodule

// File: rtl/daeq_compute_port.sv
module daeq_compute_port #(
  parameter int REG_IDX_W = 5,
  parameter int QUEUE_REG = 7
) (
  input  logic                 rd_en,
  input  logic [REG_IDX_W-1:0] rd_idx,
  input  logic                 wr_en,
  input  logic [REG_IDX_W-1:0] wr_idx,
  input  logic                 bfq,
  input  logic                 ldq_empty,
  input  logic                 sdq_full,
  input  logic                 brq_empty,
  output logic                 rd_hit,
  output logic                 stall,
  output logic                 ld_pop,
  output logic                 sd_push,
  output logic                 br_pop
);
  localparam logic [REG_IDX_W-1:0] QIDX = REG_IDX_W'(QUEUE_REG);

  logic wr_hit;
  logic go;

  assign rd_hit = rd_en && (rd_idx == QIDX);
  assign wr_hit = wr_en && (wr_idx == QIDX);

  // Any unserviceable queue operation holds the whole instruction.
  assign stall = (rd_hit && ldq_empty) || (wr_hit && sdq_full) || (bfq && brq_empty);
  assign go    = !stall;

  assign ld_pop  = rd_hit && go;
  assign sd_push = wr_hit && go;
  assign br_pop  = bfq && go;
endmodule

// File: rtl/decoupled_queue_if.sv
module decoupled_queue_if #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int REG_IDX_W = 5,
  parameter int QUEUE_REG = 7,
  parameter int DEPTH     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mem_ld_valid,
  input  logic [DATA_W-1:0]    mem_ld_data,
  output logic                 mem_ld_ready,
  input  logic                 ac_st_valid,
  input  logic [ADDR_W-1:0]    ac_st_addr,
  input  logic                 ac_br_valid,
  input  logic                 ac_br_taken,
  output logic                 ac_stall,
  input  logic                 ex_rd_en,
  input  logic [REG_IDX_W-1:0] ex_rd_idx,
  output logic [DATA_W-1:0]    ex_rd_data,
  input  logic                 ex_wr_en,
  input  logic [REG_IDX_W-1:0] ex_wr_idx,
  input  logic [DATA_W-1:0]    ex_wr_data,
  input  logic                 ex_bfq,
  output logic                 ex_bfq_taken,
  output logic                 ex_stall,
  output logic                 st_out_valid,
  output logic [ADDR_W-1:0]    st_out_addr,
  output logic [DATA_W-1:0]    st_out_data,
  input  logic                 st_out_ready,
  output logic                 ldq_full,
  output logic                 ldq_empty,
  output logic                 sdq_full,
  output logic                 sdq_empty,
  output logic                 brq_full,
  output logic                 brq_empty
);
  localparam int CW = $clog2(DEPTH + 1);

  // Named internal events, also observed by the checker.
  logic          rd_hit;
  logic          ld_push, ld_pop;
  logic          sd_push;
  logic          br_push, br_pop;
  logic          sa_push, saq_full;
  logic [CW-1:0] ld_occ, br_occ, sa_occ, sd_occ;

  assign mem_ld_ready = !ldq_full;
  assign ld_push      = mem_ld_valid && !ldq_full;

  assign ac_stall = (ac_br_valid && brq_full) || (ac_st_valid && saq_full);
  assign br_push  = ac_br_valid && !ac_stall;
  assign sa_push  = ac_st_valid && !ac_stall;

  daeq_compute_port #(.REG_IDX_W(REG_IDX_W), .QUEUE_REG(QUEUE_REG)) u_cport (
    .rd_en(ex_rd_en), .rd_idx(ex_rd_idx),
    .wr_en(ex_wr_en), .wr_idx(ex_wr_idx),
    .bfq(ex_bfq),
    .ldq_empty(ldq_empty), .sdq_full(sdq_full), .brq_empty(brq_empty),
    .rd_hit(rd_hit), .stall(ex_stall),
    .ld_pop(ld_pop), .sd_push(sd_push), .br_pop(br_pop)
  );

  daeq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_load_q (
    .clk(clk), .rst(rst),
    .push(ld_push), .push_data(mem_ld_data),
    .pop(ld_pop), .head(ex_rd_data),
    .full(ldq_full), .empty(ldq_empty), .occ(ld_occ)
  );

  daeq_fifo #(.W(1), .DEPTH(DEPTH)) u_branch_q (
    .clk(clk), .rst(rst),
    .push(br_push), .push_data(ac_br_taken),
    .pop(br_pop), .head(ex_bfq_taken),
    .full(brq_full), .empty(brq_empty), .occ(br_occ)
  );

  daeq_store_pair #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst),
    .addr_push(sa_push), .addr_in(ac_st_addr),
    .data_push(sd_push), .data_in(ex_wr_data),
    .out_ready(st_out_ready), .out_valid(st_out_valid),
    .out_addr(st_out_addr), .out_data(st_out_data),
    .addr_full(saq_full), .data_full(sdq_full), .data_empty(sdq_empty),
    .addr_occ(sa_occ), .data_occ(sd_occ)
  );
endmodule

// File: rtl/daeq_checker.sv
module daeq_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       rd_hit,
  input logic                       ld_push,
  input logic                       ld_pop,
  input logic                       br_pop,
  input logic                       ac_br_valid,
  input logic                       ldq_full,
  input logic                       ldq_empty,
  input logic                       brq_full,
  input logic                       sdq_full,
  input logic                       st_out_valid,
  input logic                       st_out_ready,
  input logic [ADDR_W-1:0]          st_out_addr,
  input logic [DATA_W-1:0]          st_out_data,
  input logic [$clog2(DEPTH+1)-1:0] ld_occ,
  input logic [$clog2(DEPTH+1)-1:0] sa_occ,
  input logic [$clog2(DEPTH+1)-1:0] sd_occ
);
  localparam int CW = $clog2(DEPTH + 1);

  a_r2_pop_drops_one: assert property (@(posedge clk) disable iff (rst)
    (ld_pop && !ld_push) |=> (ld_occ == $past(ld_occ) - CW'(1)));

  a_r6_empty_read_holds: assert property (@(posedge clk) disable iff (rst)
    (ldq_empty && rd_hit && !ld_push) |=> ldq_empty);

  a_r9_push_pop_keeps_occ: assert property (@(posedge clk) disable iff (rst)
    (ld_push && ld_pop) |=> $stable(ld_occ));

  a_r8_full_means_depth: assert property (@(posedge clk) disable iff (rst)
    ldq_full |-> (ld_occ == CW'(DEPTH)));

  a_r8_store_full_depth: assert property (@(posedge clk) disable iff (rst)
    sdq_full |-> (sd_occ == CW'(DEPTH)));

  a_r7_branch_full_holds: assert property (@(posedge clk) disable iff (rst)
    (brq_full && ac_br_valid && !br_pop) |=> brq_full);

  a_r4_store_held: assert property (@(posedge clk) disable iff (rst)
    (st_out_valid && !st_out_ready) |=>
      (st_out_valid && $stable(st_out_addr) && $stable(st_out_data)));

  a_r4_pair_present: assert property (@(posedge clk) disable iff (rst)
    st_out_valid |-> (sa_occ != '0 && sd_occ != '0));
endmodule

bind decoupled_queue_if daeq_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)
) u_daeq_checker (
  .clk(clk), .rst(rst), .rd_hit(rd_hit),
  .ld_push(ld_push), .ld_pop(ld_pop), .br_pop(br_pop),
  .ac_br_valid(ac_br_valid),
  .ldq_full(ldq_full), .ldq_empty(ldq_empty),
  .brq_full(brq_full), .sdq_full(sdq_full),
  .st_out_valid(st_out_valid), .st_out_ready(st_out_ready),
  .st_out_addr(st_out_addr), .st_out_data(st_out_data),
  .ld_occ(ld_occ), .sa_occ(sa_occ), .sd_occ(sd_occ)
);

// File: tb/decoupled_queue_if_bench.sv
module decoupled_queue_if_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int IW = 5;
  localparam int D  = 8;

  logic clk = 1'b0;
  logic rst;
  logic mem_ld_valid; logic [DW-1:0] mem_ld_data; logic mem_ld_ready;
  logic ac_st_valid; logic [AW-1:0] ac_st_addr;
  logic ac_br_valid, ac_br_taken, ac_stall;
  logic ex_rd_en; logic [IW-1:0] ex_rd_idx; logic [DW-1:0] ex_rd_data;
  logic ex_wr_en; logic [IW-1:0] ex_wr_idx; logic [DW-1:0] ex_wr_data;
  logic ex_bfq, ex_bfq_taken, ex_stall;
  logic st_out_valid; logic [AW-1:0] st_out_addr; logic [DW-1:0] st_out_data;
  logic st_out_ready;
  logic ldq_full, ldq_empty, sdq_full, sdq_empty, brq_full, brq_empty;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  decoupled_queue_if #(
    .DATA_W(DW), .ADDR_W(AW), .REG_IDX_W(IW), .QUEUE_REG(7), .DEPTH(D)
  ) u_decoupled_queue_if (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    mem_ld_valid = 0; mem_ld_data = '0;
    ac_st_valid = 0; ac_st_addr = '0;
    ac_br_valid = 0; ac_br_taken = 0;
    ex_rd_en = 0; ex_rd_idx = '0;
    ex_wr_en = 0; ex_wr_idx = '0; ex_wr_data = '0;
    ex_bfq = 0; st_out_ready = 0;
  endtask

  // Inputs set just after a falling edge; outputs read 1 time unit later.
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  function automatic logic br_pat(int i);
    return (i % 3) == 0;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1 reset state
    check("R1 ldq_empty", ldq_empty, 1);
    check("R1 sdq_empty", sdq_empty, 1);
    check("R1 brq_empty", brq_empty, 1);
    check("R1 full flags", {ldq_full, sdq_full, brq_full}, 0);
    check("R1 st_out_valid", st_out_valid, 0);

    // R8 fill load queue
    for (int i = 0; i < D; i++) begin
      step(); mem_ld_valid = 1; mem_ld_data = DW'(16'h0100 + i); #1;
      check("R8 ready while not full", mem_ld_ready, 1);
    end
    step(); mem_ld_valid = 1; mem_ld_data = 16'hDEAD; #1;
    check("R8 ldq_full", ldq_full, 1);
    check("R8 ready low when full", mem_ld_ready, 0);

    // R2 other index does not pop
    step(); ex_rd_en = 1; ex_rd_idx = 5'd3; #1;
    check("R2 non-mapped read no stall", ex_stall, 0);
    step(); #1;
    check("R2 non-mapped read keeps queue full", ldq_full, 1);

    // R2 drain in order
    for (int i = 0; i < D; i++) begin
      step(); ex_rd_en = 1; ex_rd_idx = 5'd7; #1;
      check("R2 head data", ex_rd_data, 32'h0100 + i);
      check("R2 no stall", ex_stall, 0);
    end
    step(); #1;
    check("R8 dropped word absent, ldq_empty", ldq_empty, 1);

    // R6 empty read stalls and suppresses the write
    ex_rd_en = 1; ex_rd_idx = 5'd7;
    ex_wr_en = 1; ex_wr_idx = 5'd7; ex_wr_data = 16'h0077;
    mem_ld_valid = 1; mem_ld_data = 16'h0055; #1;
    check("R6 stall on empty read", ex_stall, 1);
    step(); ex_rd_en = 1; ex_rd_idx = 5'd7; #1;
    check("R6 retry no stall", ex_stall, 0);
    check("R6 retry reads arrived data", ex_rd_data, 32'h0055);
    step(); #1;
    check("R6 queue empty after retry", ldq_empty, 1);
    check("R6 stalled write suppressed", sdq_empty, 1);

    // R9 simultaneous push and pop
    for (int i = 0; i < 3; i++) begin
      step(); mem_ld_valid = 1; mem_ld_data = DW'(16'h0200 + i);
    end
    for (int k = 0; k < 4; k++) begin
      step(); mem_ld_valid = 1; mem_ld_data = DW'(16'h0203 + k);
      ex_rd_en = 1; ex_rd_idx = 5'd7; #1;
      check("R9 pop during push", ex_rd_data, 32'h0200 + k);
    end
    for (int i = 0; i < 3; i++) begin
      step(); #1;
      check("R9 occupancy kept, not empty", ldq_empty, 0);
      ex_rd_en = 1; ex_rd_idx = 5'd7; #1;
      check("R9 drain order", ex_rd_data, 32'h0204 + i);
    end
    step(); #1;
    check("R9 empty after three", ldq_empty, 1);

    // R3 store data fill
    for (int i = 0; i < D; i++) begin
      step(); ex_wr_en = 1; ex_wr_idx = 5'd7; ex_wr_data = DW'(16'h00A0 + i); #1;
      check("R3 write no stall", ex_stall, 0);
    end
    step(); #1;
    check("R3 sdq_full", sdq_full, 1);
    check("R4 no address, no store", st_out_valid, 0);
    ex_wr_en = 1; ex_wr_idx = 5'd7; ex_wr_data = 16'h0BAD; #1;
    check("R7 write to full stalls", ex_stall, 1);
    step(); ex_wr_en = 1; ex_wr_idx = 5'd2; ex_wr_data = 16'h0222; #1;
    check("R3 non-mapped write no stall", ex_stall, 0);

    // R4 addresses, memory not ready
    for (int i = 0; i < D; i++) begin
      step(); ac_st_valid = 1; ac_st_addr = AW'(8'h10 + i); #1;
      check("R7 address no stall", ac_stall, 0);
    end
    step(); #1;
    check("R4 pair valid", st_out_valid, 1);
    check("R4 oldest address", st_out_addr, 32'h10);
    check("R4 oldest data", st_out_data, 32'h00A0);
    ac_st_valid = 1; ac_st_addr = 8'h99; #1;
    check("R7 address to full stalls", ac_stall, 1);
    for (int i = 0; i < D; i++) begin
      step(); st_out_ready = 1; #1;
      check("R4 release valid", st_out_valid, 1);
      check("R4 release address", st_out_addr, 32'h10 + i);
      check("R4 release data", st_out_data, 32'h00A0 + i);
    end
    step(); #1;
    check("R4 drained", st_out_valid, 0);
    check("R3 sdq_empty after drain", sdq_empty, 1);
    ac_st_valid = 1; ac_st_addr = 8'h30;
    step(); #1;
    check("R4 address alone not valid", st_out_valid, 0);
    ex_wr_en = 1; ex_wr_idx = 5'd7; ex_wr_data = 16'h00C0;
    step(); #1;
    check("R4 late data valid", st_out_valid, 1);
    check("R4 late pair address", st_out_addr, 32'h30);
    check("R4 late pair data", st_out_data, 32'h00C0);
    st_out_ready = 1;
    step(); #1;
    check("R4 final release", st_out_valid, 0);

    // R5 branch outcomes
    for (int i = 0; i < D; i++) begin
      step(); ac_br_valid = 1; ac_br_taken = br_pat(i); #1;
      check("R5 push no stall", ac_stall, 0);
    end
    step(); #1;
    check("R8 brq_full", brq_full, 1);
    ac_br_valid = 1; ac_br_taken = 1; #1;
    check("R7 branch push to full stalls", ac_stall, 1);
    for (int i = 0; i < D; i++) begin
      step(); ex_bfq = 1; #1;
      check("R5 outcome order", ex_bfq_taken, br_pat(i));
      check("R5 pop no stall", ex_stall, 0);
    end
    step(); #1;
    check("R5 brq_empty", brq_empty, 1);
    ex_bfq = 1; #1;
    check("R7 pop from empty stalls", ex_stall, 1);
    step(); #1;
    check("R7 still empty", brq_empty, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule